// File: doc/BRIEF.md
# Horizontal Chroma Resampler

This block changes the horizontal chroma density of a pixel stream. It converts 4:2:2 to 4:4:4 by filling in the missing colour-difference samples, converts 4:4:4 to 4:2:2 by dropping every other Cb and Cr sample, or passes pixels through untouched. Pixels arrive and leave one per beat on valid/ready streams. A start-of-frame flag rides with the first pixel of a frame, and an end-of-line flag rides with the last pixel of each line.

Every beat carries three sample lanes: luma in bits [B-1:0], the first chroma lane in [2B-1:B] and the second chroma lane in [3B-1:2B]. B is the sample width. In 4:4:4 the first chroma lane holds Cb and the second holds Cr. In 4:2:2 the first chroma lane alternates: Cb on pixels 0, 2, 4 and so on, Cr on pixels 1, 3, 5 and so on. The second lane is ignored on input and driven to zero on output. Lines have an even pixel count.

Three static inputs set the behaviour:
- `cfg_mode` selects the conversion: 0 passthrough, 1 upsample, 2 downsample, 3 treated as passthrough.
- `cfg_alg` selects the interpolation: 0 nearest neighbour, 1 two-tap linear.
- `cfg_site` selects where chroma is sited when upsampling with linear interpolation: 0 left, 1 center.

The static inputs may change only while reset is held. A rounded average of two samples is (a+b+1)>>1.

Top module: `hcr_top`

## Requirements
- R1: In passthrough mode every output beat equals the input beat in all three lanes and in both flags.
- R2: Upsampling, nearest: pixels 2k and 2k+1 both get Cb equal to the chroma of pixel 2k and Cr equal to the chroma of pixel 2k+1.
- R3: Upsampling, linear, center siting: a pixel keeps the chroma sample it carries. An even pixel's Cr is the rounded average of the chroma of pixels i-1 and i+1. An odd pixel's Cb is the rounded average of the chroma of pixels i-1 and i+1.
- R4: Upsampling, linear, left siting: pixel 2k takes Cb from pixel 2k and Cr from pixel 2k+1. Pixel 2k+1 gets Cb as the rounded average of the chroma of pixels 2k and 2k+2, and Cr as the rounded average of the chroma of pixels 2k+1 and 2k+3.
- R5: A neighbour that lies outside the line is replaced by the in-line sample of the same kind that is nearest the edge. No value is ever taken across an end-of-line flag.
- R6: Downsampling, nearest: an even pixel outputs its own Cb and an odd pixel outputs its own Cr in the first chroma lane. The second chroma lane is zero.
- R7: Downsampling, linear: an even pixel outputs the rounded average of the Cb of itself and pixel i+1. An odd pixel outputs the rounded average of the Cr of itself and pixel i-1.
- R8: Each input beat yields exactly one output beat, in order, with the start-of-frame and end-of-line flags on the same pixel positions as at the input.
- R9: While the output is valid and not accepted, the output data and flags hold steady, and no beat is lost or repeated under stalls on either side.
- R10: After reset the output is not valid until input has arrived.
- R11: With the ready register stage enabled, `s_tready` comes from a flop, is high after reset, and the output sequence is the same as without the stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Conversion select: 0 pass, 1 up, 2 down |
| cfg_alg | input | 1 | 0 nearest, 1 linear |
| cfg_site | input | 1 | 0 left, 1 center |
| s_tdata | input | 3*BPS | Input pixel {lane2, lane1, luma} |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tuser | input | 1 | Start of frame |
| s_tlast | input | 1 | End of line |
| m_tdata | output | 3*BPS | Output pixel {lane2, lane1, luma} |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tuser | output | 1 | Start of frame |
| m_tlast | output | 1 | End of line |

## Verification
The bench builds the block with 10-bit samples and the ready register stage enabled. This exercises the skid path and rounding on sample values that do not fit in 8 bits. It runs all twelve combinations of mode, interpolation and siting. Each frame starts with a two-pixel line, so both edge replacements land on the same pair, and the other lines have random widths. Random stalls on both sides drive the lookahead window into its waiting state and the output slot into back-to-back handoff.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
    typedef enum logic [1:0] {
        RS_PASS = 2'd0,
        RS_UP   = 2'd1,
        RS_DOWN = 2'd2
    } rs_mode_e;
endpackage

// File: rtl/hcr_ready_stage.sv
module hcr_ready_stage #(
    parameter int W      = 32,
    parameter bit ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_valid,
    output logic         up_ready,
    input  logic [W-1:0] up_data,
    output logic         dn_valid,
    input  logic         dn_ready,
    output logic [W-1:0] dn_data
);
    generate
        if (ENABLE) begin : g_skid
            typedef struct packed {
                logic         v;
                logic [W-1:0] b;
            } skid_t;
            skid_t skid_d, skid_q;

            always_comb begin
                skid_d = skid_q;
                if (skid_q.v) begin
                    if (dn_ready) skid_d.v = 1'b0;
                end else if (up_valid && !dn_ready) begin
                    skid_d.v = 1'b1;
                    skid_d.b = up_data;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) skid_q <= '0;
                else        skid_q <= skid_d;
            end

            assign up_ready = !skid_q.v;
            assign dn_valid = skid_q.v || up_valid;
            assign dn_data  = skid_q.v ? skid_q.b : up_data;

            // R11: a parked beat stays parked and unchanged until taken
            p_skid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
                skid_q.v && !dn_ready |=> skid_q.v && $stable(skid_q.b));
        end else begin : g_wire
            assign up_ready = dn_ready;
            assign dn_valid = up_valid;
            assign dn_data  = up_data;
        end
    endgenerate
endmodule

// File: rtl/hcr_pair_calc.sv
module hcr_pair_calc
    import hcr_pkg::*;
#(
    parameter int BPS = 10,
    localparam int PW = 3 * BPS
) (
    input  logic [1:0]     mode,
    input  logic           alg,
    input  logic           site,
    input  logic [PW-1:0]  cur_p0,
    input  logic [PW-1:0]  cur_p1,
    input  logic           cur_eol,
    input  logic           line_start,
    input  logic [BPS-1:0] prev_c,
    input  logic [BPS-1:0] nxt_c0,
    input  logic [BPS-1:0] nxt_c1,
    output logic [PW-1:0]  out_p0,
    output logic [PW-1:0]  out_p1
);
    function automatic logic [BPS-1:0] avg2(input logic [BPS-1:0] a, input logic [BPS-1:0] b);
        logic [BPS:0] s;
        s = {1'b0, a} + {1'b0, b} + {{BPS{1'b0}}, 1'b1};
        return s[BPS:1];
    endfunction

    logic [BPS-1:0] y0, y1, ch0, ch1, cb0, cb1, cr0, cr1;
    logic [BPS-1:0] nb, nr, pr;
    localparam logic [BPS-1:0] ZERO = '0;

    always_comb begin
        y0  = cur_p0[BPS-1:0];
        y1  = cur_p1[BPS-1:0];
        ch0 = cur_p0[2*BPS-1:BPS];
        ch1 = cur_p1[2*BPS-1:BPS];
        cb0 = cur_p0[2*BPS-1:BPS];
        cb1 = cur_p1[2*BPS-1:BPS];
        cr0 = cur_p0[3*BPS-1:2*BPS];
        cr1 = cur_p1[3*BPS-1:2*BPS];
        nb  = cur_eol    ? ch0 : nxt_c0;
        nr  = cur_eol    ? ch1 : nxt_c1;
        pr  = line_start ? ch1 : prev_c;
        out_p0 = cur_p0;
        out_p1 = cur_p1;
        unique case (mode)
            RS_UP: begin
                if (!alg) begin
                    out_p0 = {ch1, ch0, y0};
                    out_p1 = {ch1, ch0, y1};
                end else if (site) begin
                    out_p0 = {avg2(pr, ch1), ch0, y0};
                    out_p1 = {ch1, avg2(ch0, nb), y1};
                end else begin
                    out_p0 = {ch1, ch0, y0};
                    out_p1 = {avg2(ch1, nr), avg2(ch0, nb), y1};
                end
            end
            RS_DOWN: begin
                if (!alg) begin
                    out_p0 = {ZERO, cb0, y0};
                    out_p1 = {ZERO, cr1, y1};
                end else begin
                    out_p0 = {ZERO, avg2(cb0, cb1), y0};
                    out_p1 = {ZERO, avg2(cr0, cr1), y1};
                end
            end
            default: begin
                out_p0 = cur_p0;
                out_p1 = cur_p1;
            end
        endcase
    end
endmodule

// File: rtl/hcr_top.sv
module hcr_top
    import hcr_pkg::*;
#(
    parameter int BPS        = 10,
    parameter bit READY_PIPE = 1'b1,
    localparam int PW        = 3 * BPS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_alg,
    input  logic          cfg_site,
    input  logic [PW-1:0] s_tdata,
    input  logic          s_tvalid,
    output logic          s_tready,
    input  logic          s_tuser,
    input  logic          s_tlast,
    output logic [PW-1:0] m_tdata,
    output logic          m_tvalid,
    input  logic          m_tready,
    output logic          m_tuser,
    output logic          m_tlast
);
    localparam int BW = PW + 2;

    typedef struct packed {
        logic [PW-1:0] p0;
        logic [PW-1:0] p1;
        logic          sof;
        logic          eol;
    } pair_t;

    typedef struct packed {
        logic           half;
        logic [PW-1:0]  hold;
        logic           hold_sof;
        logic           pr_v;
        pair_t          pr;
        logic           c_v;
        pair_t          cur;
        logic [BPS-1:0] prev_c;
        logic           line_start;
        logic           o_v;
        logic           o_idx;
        pair_t          outp;
    } state_t;

    state_t st_d, st_q;

    logic [BW-1:0] in_bus, core_bus;
    logic          core_valid, core_ready;
    logic [PW-1:0] core_data, calc_p0, calc_p1;
    logic          core_user, core_last;
    logic          need_next, out_free, fire, move, take;

    assign in_bus = {s_tuser, s_tlast, s_tdata};

    hcr_ready_stage #(.W(BW), .ENABLE(READY_PIPE)) u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (s_tvalid),
        .up_ready (s_tready),
        .up_data  (in_bus),
        .dn_valid (core_valid),
        .dn_ready (core_ready),
        .dn_data  (core_bus)
    );

    assign core_user = core_bus[BW-1];
    assign core_last = core_bus[BW-2];
    assign core_data = core_bus[PW-1:0];

    hcr_pair_calc #(.BPS(BPS)) u_calc (
        .mode       (cfg_mode),
        .alg        (cfg_alg),
        .site       (cfg_site),
        .cur_p0     (st_q.cur.p0),
        .cur_p1     (st_q.cur.p1),
        .cur_eol    (st_q.cur.eol),
        .line_start (st_q.line_start),
        .prev_c     (st_q.prev_c),
        .nxt_c0     (st_q.pr.p0[2*BPS-1:BPS]),
        .nxt_c1     (st_q.pr.p1[2*BPS-1:BPS]),
        .out_p0     (calc_p0),
        .out_p1     (calc_p1)
    );

    always_comb begin
        need_next  = (cfg_mode == RS_UP) && cfg_alg;
        out_free   = !st_q.o_v || (st_q.o_idx && m_tready);
        fire       = st_q.c_v && out_free && (st_q.cur.eol || !need_next || st_q.pr_v);
        move       = st_q.pr_v && (!st_q.c_v || fire);
        core_ready = !(st_q.half && st_q.pr_v);
        take       = core_valid && core_ready;

        st_d = st_q;

        // window: load the next pair, or empty after producing
        if (move) begin
            st_d.cur  = st_q.pr;
            st_d.c_v  = 1'b1;
            st_d.pr_v = 1'b0;
        end else if (fire) begin
            st_d.c_v = 1'b0;
        end

        // output slot: two beats per pair
        if (fire) begin
            st_d.outp.p0      = calc_p0;
            st_d.outp.p1      = calc_p1;
            st_d.outp.sof     = st_q.cur.sof;
            st_d.outp.eol     = st_q.cur.eol;
            st_d.o_v          = 1'b1;
            st_d.o_idx        = 1'b0;
            st_d.prev_c       = st_q.cur.p1[2*BPS-1:BPS];
            st_d.line_start   = st_q.cur.eol;
        end else if (st_q.o_v && m_tready) begin
            if (st_q.o_idx) st_d.o_v   = 1'b0;
            else            st_d.o_idx = 1'b1;
        end

        // pair assembler
        if (take) begin
            if (!st_q.half) begin
                st_d.hold     = core_data;
                st_d.hold_sof = core_user;
                st_d.half     = 1'b1;
            end else begin
                st_d.pr.p0  = st_q.hold;
                st_d.pr.p1  = core_data;
                st_d.pr.sof = st_q.hold_sof;
                st_d.pr.eol = core_last;
                st_d.pr_v   = 1'b1;
                st_d.half   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.line_start <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_tvalid = st_q.o_v;
    assign m_tdata  = st_q.o_idx ? st_q.outp.p1 : st_q.outp.p0;
    assign m_tuser  = !st_q.o_idx && st_q.outp.sof;
    assign m_tlast  = st_q.o_idx && st_q.outp.eol;

    // R9: stalled output holds its beat
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast));

    // R10: nothing is presented right after reset
    p_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !m_tvalid);

    // R8: the first beat of a pair is always followed by its partner
    p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && m_tready && !m_tlast && !st_q.o_idx |=> m_tvalid);

    // R6: downsampled beats leave the second chroma lane empty
    p_down_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && (cfg_mode == RS_DOWN) |-> m_tdata[3*BPS-1:2*BPS] == '0);
endmodule

// File: tb/test_hcr_top.sv
module test_hcr_top;
    localparam int BPS = 10;
    localparam int PW  = 3 * BPS;
    localparam int MAXW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic          cfg_alg = 1'b0;
    logic          cfg_site = 1'b0;
    logic [PW-1:0] s_tdata = '0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic          s_tuser = 1'b0;
    logic          s_tlast = 1'b0;
    logic [PW-1:0] m_tdata;
    logic          m_tvalid;
    logic          m_tready = 1'b0;
    logic          m_tuser;
    logic          m_tlast;

    always #10 clk = ~clk;

    hcr_top #(.BPS(BPS), .READY_PIPE(1'b1)) i_hcr_top (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_alg(cfg_alg), .cfg_site(cfg_site),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tuser(m_tuser), .m_tlast(m_tlast)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [PW-1:0] iq_d[$];
    bit            iq_u[$];
    bit            iq_l[$];
    logic [PW-1:0] eq_d[$];
    bit            eq_u[$];
    bit            eq_l[$];
    string         eq_t[$];

    function automatic int avg(input int a, input int b);
        return (a + b + 1) / 2;
    endfunction

    task automatic check(input string tag, input bit ok, input logic [PW+1:0] act, input logic [PW+1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic add_line(input int w, input bit first, input int mode, input int alg, input int site);
        int y[MAXW];
        int cb[MAXW];
        int cr[MAXW];
        int c[MAXW];
        for (int i = 0; i < w; i++) begin
            y[i]  = int'($urandom_range(1023));
            cb[i] = int'($urandom_range(1023));
            cr[i] = (mode == 1) ? 0 : int'($urandom_range(1023));
            c[i]  = cb[i];
            iq_d.push_back({cr[i][BPS-1:0], cb[i][BPS-1:0], y[i][BPS-1:0]});
            iq_u.push_back(first && i == 0);
            iq_l.push_back(i == w - 1);
        end
        for (int i = 0; i < w; i++) begin
            int ob, orr, nb;
            string tag;
            bit odd;
            odd = (i % 2) == 1;
            ob = cb[i];
            orr = cr[i];
            tag = "R1";
            if (mode == 1) begin
                if (alg == 0) begin
                    tag = "R2";
                    ob  = c[i & ~1];
                    orr = c[i | 1];
                end else if (site == 1) begin
                    tag = "R3";
                    if (!odd) begin
                        ob  = c[i];
                        orr = avg((i > 0) ? c[i-1] : c[i+1], c[i+1]);
                        if (i == 0) tag = "R5";
                    end else begin
                        orr = c[i];
                        ob  = avg(c[i-1], (i + 1 < w) ? c[i+1] : c[i-1]);
                        if (i + 1 >= w) tag = "R5";
                    end
                end else begin
                    tag = "R4";
                    if (!odd) begin
                        ob  = c[i];
                        orr = c[i+1];
                    end else begin
                        nb  = (i + 1 < w) ? c[i+1] : c[i-1];
                        ob  = avg(c[i-1], nb);
                        orr = avg(c[i], (i + 2 < w) ? c[i+2] : c[i]);
                        if (i + 1 >= w) tag = "R5";
                    end
                end
            end else if (mode == 2) begin
                tag = (alg == 0) ? "R6" : "R7";
                orr = 0;
                if (!odd) ob = (alg == 0) ? cb[i] : avg(cb[i], cb[i+1]);
                else      ob = (alg == 0) ? cr[i] : avg(cr[i-1], cr[i]);
            end
            eq_d.push_back({orr[BPS-1:0], ob[BPS-1:0], y[i][BPS-1:0]});
            eq_u.push_back(first && i == 0);
            eq_l.push_back(i == w - 1);
            eq_t.push_back(tag);
        end
    endtask

    task automatic run_cfg(input int mode, input int alg, input int site);
        int idx;
        int cyc;
        iq_d.delete(); iq_u.delete(); iq_l.delete();
        eq_d.delete(); eq_u.delete(); eq_l.delete(); eq_t.delete();
        @(negedge clk);
        rst_n    = 1'b0;
        s_tvalid = 1'b0;
        m_tready = 1'b0;
        cfg_mode = mode[1:0];
        cfg_alg  = alg[0];
        cfg_site = site[0];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 valid after reset", m_tvalid == 1'b0, {1'b0, 1'b0, {PW{1'b0}}} | m_tvalid, '0);
        check("R11 ready after reset", s_tready == 1'b1, {{(PW+1){1'b0}}, s_tready}, {{(PW+1){1'b0}}, 1'b1});
        add_line(2, 1'b1, mode, alg, site);
        for (int l = 0; l < 3; l++) add_line(2 * int'($urandom_range(1, 7)), 1'b0, mode, alg, site);
        add_line(2, 1'b0, mode, alg, site);
        idx = 0;
        cyc = 0;
        while (eq_d.size() > 0 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (idx < iq_d.size() && ($urandom_range(99) < 70)) begin
                s_tvalid = 1'b1;
                s_tdata  = iq_d[idx];
                s_tuser  = iq_u[idx];
                s_tlast  = iq_l[idx];
            end else begin
                s_tvalid = 1'b0;
            end
            if (s_tvalid && s_tready) idx++;
            m_tready = ($urandom_range(99) < 65);
            if (m_tvalid && m_tready) begin
                logic [PW+1:0] a, e;
                a = {m_tuser, m_tlast, m_tdata};
                e = {eq_u[0], eq_l[0], eq_d[0]};
                if (a[PW+1:PW] != e[PW+1:PW])
                    check("R8 flags", 1'b0, a, e);
                else
                    check(eq_t[0], a == e, a, e);
                void'(eq_d.pop_front()); void'(eq_u.pop_front());
                void'(eq_l.pop_front()); void'(eq_t.pop_front());
            end
        end
        s_tvalid = 1'b0;
        if (cyc >= 5000) check("R9 watchdog expired", 1'b0, '0, '1);
        m_tready = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check("R9 no extra beat", m_tvalid == 1'b0, {{(PW+1){1'b0}}, m_tvalid}, '0);
        end
    endtask

    initial begin
        for (int m = 0; m < 3; m++)
            for (int a = 0; a < 2; a++)
                for (int s = 0; s < 2; s++)
                    run_cfg(m, a, s);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule